// File: doc/BRIEF.md
# UART Register Front End

This block is the bus-facing register file of a simple serial port. A processor reaches it over a 32-bit word-addressed register bus. Bytes coming from the line side arrive on a valid/ready byte stream and are held in an eight-entry receive queue. Software drains the queue by reading the data register. Bytes written to the data register leave at once on a transmit byte output. Bit-level framing, baud generation, flow control and DMA are handled elsewhere. The divider, oversampling, pin, DMA and wake registers are plain storage that other logic decodes.

The receive stream follows a simple back-pressure rule. A byte is taken on any rising clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is low while the baud clock enable in the control register is clear, and also while the queue is full. A byte offered while `rx_ready` is low stays with the sender. The transmit side is treated as always empty: `tx_valid` pulses for one cycle and carries no ready. The interrupt output is a level signal built from an interrupt flag register and an interrupt enable register.

Word offsets, each a multiple of 4 starting at 0x00: control, status, interrupt enable, interrupt flag, clock divider, oversampling, peek, pin, data, DMA, wake enable, wake flag.

Top module: `uart_regfront`

## Requirements
- R1: The receive queue holds 8 bytes. `rx_ready` is high only while control bit 12 (baud clock enable) is set and fewer than 8 bytes are queued. While `rx_ready` is low, `rx_valid` changes nothing.
- R2: When a byte is accepted and the queue count after that cycle is at least control bits [3:0], the receive-threshold flag (flag register bit 4) is set. The flag stays set until software clears it.
- R3: `irq` is high exactly when some bit is set in both the interrupt flag register and the interrupt enable register.
- R4: A write to the flag register clears every flag bit where the written word has a one, and leaves the other flag bits as they were. If hardware sets a flag in the same cycle as a clear, the set wins.
- R5: A control write with bit 8 set empties the receive queue. This includes a byte accepted in the same cycle, and such a byte does not set the threshold flag. Bits 8 and 9 of the control register are never stored, so they always read back as 0.
- R6: A control write with bit 12 set also stores bit 13 (baud clock ready) as 1. All other written control bits are stored as given.
- R7: A status read returns:
  - the queue count in bits [11:8];
  - bit 6 (transmit empty) always 1;
  - bit 4 (receive empty) set when the queue is empty;
  - all other bits 0.
  Writes to the status register have no effect.
- R8: A read of the data register returns the oldest queued byte and removes it. On an empty queue, the read returns 0 and changes nothing. A read of the peek register returns the oldest byte without removing it, or 0 when the queue is empty.
- R9: A write to the data register drives its low 8 bits on `tx_data`, with `tx_valid` high for exactly the following cycle. The same write sets the transmit flag (flag register bit 6).
- R10: After reset:
  - the pin register reads 0x2 (bit 1 set);
  - status reads 0x50;
  - the queue is empty, `irq` is low and `tx_valid` is low;
  - every other register reads 0.
- R11: An address with nonzero bits [1:0], or a word offset at or above 0x30, is unmapped. Unmapped reads return 0, and unmapped writes change nothing.
- R12: A byte accepted in the same cycle as a data-register pop is queued behind the remaining bytes. The count is unchanged and arrival order is kept.
- R13: The interrupt enable, clock divider, oversampling, pin, DMA, wake enable and wake flag registers store all 32 written bits and read them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a data read pops on the clock edge |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current state |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte can be accepted |
| rx_data | input | 8 | Receive byte |
| tx_valid | output | 1 | One-cycle pulse carrying a transmitted byte |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
Two things can happen in the same cycle: a byte arrives on the receive stream, and a bus access touches the same state. The bus access may pop the data register, flush through the control register, or clear flags in the flag register. The bench provokes this by holding `rx_valid` high in the very cycle it drives the bus strobe. It then judges the result through later reads:
- after a pop, the popped value, the new level and the order in which the remaining bytes drain;
- after a flush, a level of zero;
- after a flag clear, that the threshold flag stayed set because the hardware set wins.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int NUM_REGS = 12;

  typedef enum logic [3:0] {
    RI_CTRL = 4'd0,
    RI_STAT = 4'd1,
    RI_IEN  = 4'd2,
    RI_IFL  = 4'd3,
    RI_CDIV = 4'd4,
    RI_OSR  = 4'd5,
    RI_PEEK = 4'd6,
    RI_PIN  = 4'd7,
    RI_DATA = 4'd8,
    RI_DMA  = 4'd9,
    RI_WKEN = 4'd10,
    RI_WKFL = 4'd11
  } reg_idx_e;

  // control register fields
  localparam int CTL_THR_LSB  = 0;
  localparam int CTL_THR_W    = 4;
  localparam int CTL_FLUSH_RX = 8;
  localparam int CTL_FLUSH_TX = 9;
  localparam int CTL_CLK_EN   = 12;
  localparam int CTL_CLK_RDY  = 13;

  // status register fields
  localparam int ST_RX_EMPTY  = 4;
  localparam int ST_TX_EMPTY  = 6;
  localparam int ST_LVL_LSB   = 8;

  // interrupt flag / enable bits
  localparam int IRQ_RX_THD   = 4;
  localparam int IRQ_TX_HE    = 6;

  // pin register
  localparam int PIN_RTS      = 1;

  // plain storage slots
  localparam int NUM_PLAIN = 6;

  function automatic reg_idx_e plain_slot_idx(input int slot);
    case (slot)
      0:       return RI_CDIV;
      1:       return RI_OSR;
      2:       return RI_PIN;
      3:       return RI_DMA;
      4:       return RI_WKEN;
      default: return RI_WKFL;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] plain_slot_rst(input int slot);
    logic [DATA_W-1:0] v;
    v = '0;
    if (slot == 2) v[PIN_RTS] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/uart_rf_fifo.sv
module uart_rf_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];
  assign count   = cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= din;
  end

endmodule

// File: rtl/uart_rf_irq.sv
module uart_rf_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] en_q,
  output logic [W-1:0] flag_q,
  output logic         irq
);

  logic [W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_we) en_q <= en_wdata;
      flag_q <= (flag_q & ~clr_eff) | set_mask;
    end
  end

  assign irq = |(flag_q & en_q);

endmodule

// File: rtl/uart_rf_store.sv
module uart_rf_store #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_VAL;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int RX_DEPTH = 8,
  localparam int WORD_W  = ADDR_W - 2,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);

  // address decode
  logic [WORD_W-1:0] word;
  logic              mapped;
  reg_idx_e          idx;
  logic              wr_hit [NUM_REGS];
  logic              rd_hit [NUM_REGS];

  assign word   = reg_addr[ADDR_W-1:2];
  assign mapped = (reg_addr[1:0] == 2'b00) && (word < WORD_W'(NUM_REGS));
  assign idx    = reg_idx_e'(word[3:0]);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
    assign wr_hit[r] = reg_wr && mapped && (idx == reg_idx_e'(r));
    assign rd_hit[r] = reg_rd && mapped && (idx == reg_idx_e'(r));
  end

  // control register
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              flush_rx;

  always_comb begin
    ctrl_d = reg_wdata;
    ctrl_d[CTL_FLUSH_RX] = 1'b0;
    ctrl_d[CTL_FLUSH_TX] = 1'b0;
    if (reg_wdata[CTL_CLK_EN]) ctrl_d[CTL_CLK_RDY] = 1'b1;
  end

  assign flush_rx = wr_hit[RI_CTRL] && reg_wdata[CTL_FLUSH_RX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ctrl_q <= '0;
    else if (wr_hit[RI_CTRL]) ctrl_q <= ctrl_d;
  end

  // receive queue
  logic [BYTE_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_count;
  logic              fifo_empty, fifo_full;
  logic              rx_push, rx_pop;

  assign rx_ready = ctrl_q[CTL_CLK_EN] && !fifo_full;
  assign rx_push  = rx_valid && rx_ready;
  assign rx_pop   = rd_hit[RI_DATA] && !fifo_empty;

  uart_rf_fifo #(
    .DEPTH (RX_DEPTH),
    .W     (BYTE_W)
  ) u_rx_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_rx),
    .push  (rx_push),
    .din   (rx_data),
    .pop   (rx_pop),
    .head  (fifo_head),
    .count (fifo_count),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  // threshold detection on the count after this cycle
  logic [CNT_W:0] cnt_after;
  logic [CNT_W:0] thr_ext;
  logic           thr_hit;

  always_comb begin
    cnt_after = {1'b0, fifo_count};
    if (rx_push) cnt_after = cnt_after + 1'b1;
    if (rx_pop)  cnt_after = cnt_after - 1'b1;
  end

  assign thr_ext = (CNT_W + 1)'(ctrl_q[CTL_THR_LSB +: CTL_THR_W]);
  assign thr_hit = rx_push && !flush_rx && (cnt_after >= thr_ext);

  // interrupt flags and enables
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] ien_q, flag_q;

  always_comb begin
    set_mask = '0;
    set_mask[IRQ_RX_THD] = thr_hit;
    set_mask[IRQ_TX_HE]  = wr_hit[RI_DATA];
  end

  uart_rf_irq #(
    .W (DATA_W)
  ) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (wr_hit[RI_IEN]),
    .en_wdata (reg_wdata),
    .clr_we   (wr_hit[RI_IFL]),
    .clr_mask (reg_wdata),
    .set_mask (set_mask),
    .en_q     (ien_q),
    .flag_q   (flag_q),
    .irq      (irq)
  );

  // plain storage registers
  logic [DATA_W-1:0] plain_q [NUM_PLAIN];

  for (genvar s = 0; s < NUM_PLAIN; s++) begin : g_plain
    uart_rf_store #(
      .W       (DATA_W),
      .RST_VAL (plain_slot_rst(s))
    ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_hit[plain_slot_idx(s)]),
      .wdata (reg_wdata),
      .q     (plain_q[s])
    );
  end

  // transmit output
  logic              tx_valid_q;
  logic [BYTE_W-1:0] tx_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= wr_hit[RI_DATA];
      if (wr_hit[RI_DATA]) tx_data_q <= reg_wdata[BYTE_W-1:0];
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;

  // status word
  logic [DATA_W-1:0] status_w;

  always_comb begin
    status_w = '0;
    status_w[ST_LVL_LSB +: CNT_W] = fifo_count;
    status_w[ST_TX_EMPTY] = 1'b1;
    status_w[ST_RX_EMPTY] = fifo_empty;
  end

  // read mux
  logic [DATA_W-1:0] head_w;

  assign head_w = fifo_empty ? '0 : DATA_W'(fifo_head);

  always_comb begin
    reg_rdata = '0;
    if (mapped) begin
      case (idx)
        RI_CTRL: reg_rdata = ctrl_q;
        RI_STAT: reg_rdata = status_w;
        RI_IEN:  reg_rdata = ien_q;
        RI_IFL:  reg_rdata = flag_q;
        RI_CDIV: reg_rdata = plain_q[0];
        RI_OSR:  reg_rdata = plain_q[1];
        RI_PEEK: reg_rdata = head_w;
        RI_PIN:  reg_rdata = plain_q[2];
        RI_DATA: reg_rdata = head_w;
        RI_DMA:  reg_rdata = plain_q[3];
        RI_WKEN: reg_rdata = plain_q[4];
        RI_WKFL: reg_rdata = plain_q[5];
        default: reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       flag_q,
  input logic [CNT_W-1:0]  fifo_count
);

  logic [ADDR_W-3:0] w;
  logic              al, mapped;

  assign w      = reg_addr[ADDR_W-1:2];
  assign al     = (reg_addr[1:0] == 2'b00);
  assign mapped = al && (w < (ADDR_W-2)'(12));

  // R1: the queue never holds more than its depth
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  // R1: a full queue refuses bytes
  p_full_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CNT_W'(DEPTH)) |-> !rx_ready);

  // R4: written flag bits are clear next cycle when no byte is taken
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && al && w == (ADDR_W-2)'(3) && !(rx_valid && rx_ready))
      |=> ((flag_q & $past(reg_wdata)) == 32'd0));

  // R5: flush empties the queue
  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && al && w == '0 && reg_wdata[8]) |=> (fifo_count == '0));

  // R6: clock enable forces ready; flush bits never stored
  p_clk_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && al && w == '0 && reg_wdata[12])
      |=> (ctrl_q[13] && !ctrl_q[8] && !ctrl_q[9]));

  // R7: status always reports transmit empty and the receive-empty bit
  p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && al && w == (ADDR_W-2)'(1))
      |-> (reg_rdata[6] && (reg_rdata[4] == (fifo_count == '0))));

  // R8: a data read on an empty queue changes nothing
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && al && w == (ADDR_W-2)'(8) && fifo_count == '0
      && !(rx_valid && rx_ready)) |=> (fifo_count == '0));

  // R9: a data write produces a one-cycle transmit pulse with its low byte
  p_tx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && al && w == (ADDR_W-2)'(8))
      |=> (tx_valid && tx_data == $past(reg_wdata[7:0])));

  // R11: unmapped reads return zero
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !mapped) |-> (reg_rdata == 32'd0));

endmodule

bind uart_regfront uart_regfront_chk #(
  .ADDR_W (ADDR_W),
  .DEPTH  (RX_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_data    (tx_data),
  .ctrl_q     (ctrl_q),
  .flag_q     (flag_q),
  .fifo_count (fifo_count)
);

// File: tb/tb_uart_regfront.sv
module tb_uart_regfront;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;

  localparam logic [AW-1:0] A_CTRL = 10'h00, A_STAT = 10'h04, A_IEN = 10'h08,
    A_IFL = 10'h0C, A_CDIV = 10'h10, A_OSR = 10'h14, A_PEEK = 10'h18,
    A_PIN = 10'h1C, A_DATA = 10'h20, A_DMA = 10'h24, A_WKEN = 10'h28,
    A_WKFL = 10'h2C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [7:0]    rx_data = '0;
  logic          tx_valid;
  logic [7:0]    tx_data;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        last_tx_v;
  logic [7:0]  last_tx_d;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regfront #(.ADDR_W(AW), .RX_DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    last_tx_v = tx_valid;
    last_tx_d = tx_data;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_reg(input logic [AW-1:0] a, input logic [31:0] e,
                            input string tag);
    logic [31:0] v;
    bus_read(a, v);
    check(v === e, tag, v, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] regs [12];
    logic [31:0]   rst_exp [12];
    regs = '{A_CTRL, A_STAT, A_IEN, A_IFL, A_CDIV, A_OSR, A_PEEK, A_PIN,
             A_DATA, A_DMA, A_WKEN, A_WKFL};
    rst_exp = '{32'h0, 32'h50, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h2,
                32'h0, 32'h0, 32'h0, 32'h0};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset values
    for (int i = 0; i < 12; i++) expect_reg(regs[i], rst_exp[i], "R10 reset value");
    check(irq === 1'b0, "R10 irq low", 32'(irq), 0);
    check(tx_valid === 1'b0, "R10 tx idle", 32'(tx_valid), 0);

    // R1: clock disabled refuses data
    check(rx_ready === 1'b0, "R1 ready low with clock off", 32'(rx_ready), 0);
    push(8'h77);
    expect_reg(A_STAT, 32'h50, "R1 byte refused with clock off");

    // R11: unmapped and misaligned
    expect_reg(10'h030, 32'h0, "R11 unmapped read");
    expect_reg(10'h3FC, 32'h0, "R11 unmapped high read");
    bus_write(10'h031, 32'hFFFF_FFFF);
    bus_write(10'h01D, 32'hFFFF_FFFF);
    bus_write(10'h3FC, 32'hFFFF_FFFF);
    for (int i = 0; i < 12; i++) expect_reg(regs[i], rst_exp[i], "R11 unmapped write no effect");

    // R13: plain storage
    for (int i = 0; i < 12; i++) begin
      if (i == 2 || (i >= 4 && i != 6 && i != 8)) begin
        logic [31:0] pat;
        pat = 32'hA55A_0000 ^ (32'(i) * 32'h0101_1011);
        bus_write(regs[i], pat);
        expect_reg(regs[i], pat, "R13 storage readback");
        bus_write(regs[i], ~pat);
        expect_reg(regs[i], ~pat, "R13 storage readback inverted");
      end
    end
    bus_write(A_IEN, 32'h0);

    // R7: status writes ignored
    bus_write(A_STAT, 32'hFFFF_FFFF);
    expect_reg(A_STAT, 32'h50, "R7 status write ignored");

    // R5 R6: control store with flush bits and clock enable
    bus_write(A_CTRL, 32'h0000_1305);
    expect_reg(A_CTRL, 32'h0000_3005, "R6 ready forced, R5 flush bits zero");
    bus_write(A_CTRL, 32'h0000_2000);
    expect_reg(A_CTRL, 32'h0000_2000, "R6 ready stored as written");

    // R2 R7 R8 R1: sweep all thresholds over every fill level
    for (int thr = 0; thr < 16; thr++) begin
      bus_write(A_CTRL, 32'h0000_1100 | 32'(thr));
      bus_write(A_IFL, 32'hFFFF_FFFF);
      for (int n = 1; n <= 8; n++) begin
        push(8'((thr << 4) + n));
        expect_reg(A_IFL, (n >= thr) ? 32'h10 : 32'h0, "R2 threshold flag");
        expect_reg(A_STAT, 32'h40 | (32'(n) << 8), "R7 status level");
      end
      check(rx_ready === 1'b0, "R1 ready low when full", 32'(rx_ready), 0);
      push(8'hEE);
      expect_reg(A_STAT, 32'h840, "R1 full queue ignores byte");
      for (int k = 1; k <= 8; k++) begin
        expect_reg(A_PEEK, 32'((thr << 4) + k), "R8 peek head");
        expect_reg(A_DATA, 32'((thr << 4) + k), "R8 pop order");
      end
      expect_reg(A_DATA, 32'h0, "R8 empty read zero");
      expect_reg(A_STAT, 32'h50, "R8 empty read no change");
    end

    // R9 R3 R4: transmit, interrupt and flag clear
    bus_write(A_IFL, 32'hFFFF_FFFF);
    bus_write(A_DATA, 32'h1234_56C3);
    check(last_tx_v === 1'b1, "R9 tx pulse", 32'(last_tx_v), 1);
    check(last_tx_d === 8'hC3, "R9 tx byte", 32'(last_tx_d), 32'hC3);
    @(negedge clk);
    check(tx_valid === 1'b0, "R9 pulse one cycle", 32'(tx_valid), 0);
    expect_reg(A_IFL, 32'h40, "R9 transmit flag");
    check(irq === 1'b0, "R3 irq masked", 32'(irq), 0);
    bus_write(A_IEN, 32'h40);
    check(irq === 1'b1, "R3 irq enabled flag", 32'(irq), 1);
    bus_write(A_CTRL, 32'h0000_1101);
    push(8'h11);
    expect_reg(A_IFL, 32'h50, "R2 flag set at threshold 1");
    bus_write(A_IFL, 32'h10);
    expect_reg(A_IFL, 32'h40, "R4 partial clear");
    bus_write(A_IEN, 32'h10);
    check(irq === 1'b0, "R3 irq low enable mismatch", 32'(irq), 0);
    bus_write(A_IFL, 32'h40);
    expect_reg(A_IFL, 32'h0, "R4 clear remaining");

    // R4: set and clear in the same cycle, set wins
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h22;
    reg_wr = 1'b1; reg_addr = A_IFL; reg_wdata = 32'h10;
    @(negedge clk);
    rx_valid = 1'b0; reg_wr = 1'b0;
    expect_reg(A_IFL, 32'h10, "R4 set wins over clear");
    check(irq === 1'b1, "R3 irq from threshold flag", 32'(irq), 1);

    // R12: push and pop in the same cycle (queue holds 11, 22)
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h33;
    reg_rd = 1'b1; reg_addr = A_DATA;
    #1 rv = reg_rdata;
    @(negedge clk);
    rx_valid = 1'b0; reg_rd = 1'b0;
    check(rv === 32'h11, "R12 pop value", rv, 32'h11);
    expect_reg(A_STAT, 32'h240, "R12 level unchanged");
    expect_reg(A_DATA, 32'h22, "R12 order 1");
    expect_reg(A_DATA, 32'h33, "R12 order 2");

    // R5: flush with a byte accepted in the same cycle
    push(8'h44);
    bus_write(A_IFL, 32'hFFFF_FFFF);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h55;
    reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 32'h0000_1101;
    @(negedge clk);
    rx_valid = 1'b0; reg_wr = 1'b0;
    expect_reg(A_STAT, 32'h50, "R5 flush drops same-cycle byte");
    expect_reg(A_IFL, 32'h0, "R5 flushed byte sets no flag");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule